// File: doc/BRIEF.md
# DTMF Tone-Pair Steering and Digit Latch

This block is the digital steering stage of a DTMF receiver. A tone detector ahead of it supplies a signal-present flag and the row and column indices of the tone pair it hears. Two programmable guard times decide when a pair counts as a digit. The on-guard sets how long the signal must be present before the pair is accepted. The off-guard sets how long it must be gone before the digit is released. Short bursts are therefore rejected, and brief dropouts inside a held digit are bridged.

When a pair is accepted, its 4-bit digit code is written into a receive register and a guard output goes high. A configurable number of clock cycles later, a delayed-steering flag rises. Software sees the code and the flag through a small register-read port. The flag can also pull an active-low interrupt line. There is no data stream to throttle: reads are single requests, each answered one cycle later, and the port has no back-pressure.

Top module: `dtmf_steer`

## Requirements
- R1: After a synchronous reset, the receive code is 0000, `guard_out` and `dly_flag` are low, and `int_n` is high.
- R2: A pair is accepted only on the clock edge at which `tone_ok` has been sampled high for `on_guard` consecutive edges, with 0 treated as 1. A low sample restarts the count. A burst of `on_guard`-1 edges latches nothing.
- R3: `guard_out` goes high on the accepting edge. While the digit is held, `guard_out` follows `tone_ok` and is never high unless `tone_ok` was high on the previous edge.
- R4: `dly_flag` rises exactly `SETTLE_CYC` edges (1 to 4) after the accepting edge, and never on the same edge.
- R5: The receive code changes only on an accepting edge. Index changes at any other time leave it unchanged.
- R6: Once `dly_flag` is high, it clears on the edge at which `tone_ok` has been sampled low for `off_guard` consecutive edges, with 0 treated as 1. Shorter dropouts are ignored.
- R7: Row index 0..3 stands for 697/770/852/941 Hz and column index 0..3 for 1209/1336/1477/1633 Hz. Digits 1..9 (rows 0..2, columns 0..2, row-major) give codes 1..9. Row 3 gives 1011 (*) at column 0, 1010 (0) at column 1 and 1100 (#) at column 2. Column 3 gives 1101, 1110, 1111 and 0000 for rows 0..3.
- R8: A read pulses `rd_en` with `rd_addr`. One edge later, `rd_valid` is high for one cycle and `rd_data` holds the receive code for address 0, or the status {0,0,`guard_out`,`dly_flag`} for address 1.
- R9: `int_n` is low exactly when `dly_flag` and `int_en` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tone_ok | input | 1 | Signal-present flag from the detector |
| low_sel | input | 2 | Row (low-group) tone index |
| high_sel | input | 2 | Column (high-group) tone index |
| on_guard | input | CNT_W | Presence guard time in cycles |
| off_guard | input | CNT_W | Absence guard time in cycles |
| int_en | input | 1 | Interrupt mode enable |
| rd_en | input | 1 | Read request |
| rd_addr | input | 1 | 0 = receive code, 1 = status |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 4 | Read data |
| guard_out | output | 1 | Guard-time output |
| dly_flag | output | 1 | Delayed-steering flag |
| int_n | output | 1 | Active-low interrupt |

## Verification
The presence side is tried with three bursts: one exactly one edge short of the on-guard, one broken by a single low cycle and then resumed, and one of exactly the on-guard. Together they separate a consecutive-count qualifier from a cumulative one and locate the accepting edge. The release side is tried with a dropout one edge short of the off-guard followed by a full-length absence, which shows that short gaps are bridged and that the release lands on the expected edge. All sixteen row/column pairs are cycled through full digits to check the encoding. Changing the indices while a digit is held shows whether the code latch is truly edge-gated.

// File: rtl/dtmf_steer_pkg.sv
package dtmf_steer_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SETTLE, ST_HOLD} steer_state_t;

  function automatic logic [3:0] pair_code(input logic [1:0] row, input logic [1:0] col);
    logic [3:0] r4;
    r4 = {2'b00, row};
    if (col == 2'd3)        pair_code = r4 + 4'd13;   // 13,14,15 then wraps to 0
    else if (row != 2'd3)   pair_code = r4 * 4'd3 + {2'b00, col} + 4'd1;
    else if (col == 2'd0)   pair_code = 4'd11;
    else if (col == 2'd1)   pair_code = 4'd10;
    else                    pair_code = 4'd12;
  endfunction
endpackage

// File: rtl/dtmf_guard_fsm.sv
module dtmf_guard_fsm
  import dtmf_steer_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int SETTLE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tone_ok,
  input  logic [CNT_W-1:0] on_guard,
  input  logic [CNT_W-1:0] off_guard,
  output logic             accept,
  output logic             guard_out,
  output logic             dly_flag
);
  localparam int SW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [SW-1:0] S_LAST = SW'(SETTLE_CYC - 1);

  steer_state_t     state;
  logic [CNT_W-1:0] run_cnt;
  logic [SW-1:0]    set_cnt;
  logic [CNT_W:0]   on_eff, off_eff, run_next;

  assign on_eff   = (on_guard  == '0) ? (CNT_W+1)'(1) : {1'b0, on_guard};
  assign off_eff  = (off_guard == '0) ? (CNT_W+1)'(1) : {1'b0, off_guard};
  assign run_next = {1'b0, run_cnt} + (CNT_W+1)'(1);
  assign accept   = (state == ST_IDLE) && tone_ok && (run_next >= on_eff);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      run_cnt   <= '0;
      set_cnt   <= '0;
      guard_out <= 1'b0;
      dly_flag  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          guard_out <= 1'b0;
          if (!tone_ok)   run_cnt <= '0;
          else if (accept) begin
            state     <= ST_SETTLE;
            run_cnt   <= '0;
            set_cnt   <= '0;
            guard_out <= 1'b1;
          end else        run_cnt <= run_next[CNT_W-1:0];
        end
        ST_SETTLE: begin
          guard_out <= tone_ok;
          if (set_cnt == S_LAST) begin
            dly_flag <= 1'b1;
            state    <= ST_HOLD;
            run_cnt  <= '0;
          end else set_cnt <= set_cnt + SW'(1);
        end
        default: begin
          guard_out <= tone_ok;
          if (tone_ok) run_cnt <= '0;
          else if (run_next >= off_eff) begin
            dly_flag  <= 1'b0;
            state     <= ST_IDLE;
            run_cnt   <= '0;
          end else run_cnt <= run_next[CNT_W-1:0];
        end
      endcase
    end
  end

  p_accept_needs_tone_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(guard_out) |-> $past(tone_ok));
  p_guard_follows_tone_r3: assert property (@(posedge clk) disable iff (rst)
    guard_out |-> $past(tone_ok));
  p_flag_not_with_accept_r4: assert property (@(posedge clk) disable iff (rst)
    accept |-> !dly_flag);
  p_flag_after_settle_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(dly_flag) |-> $past(state) == ST_SETTLE);
  p_release_on_absence_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(dly_flag) |-> !$past(tone_ok));
endmodule

// File: rtl/dtmf_code_latch.sv
module dtmf_code_latch
  import dtmf_steer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [1:0] low_sel,
  input  logic [1:0] high_sel,
  output logic [3:0] code_q
);
  always_ff @(posedge clk) begin
    if (rst)       code_q <= 4'd0;
    else if (load) code_q <= pair_code(low_sel, high_sel);
  end
endmodule

// File: rtl/dtmf_reg_read.sv
module dtmf_reg_read (
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_en,
  input  logic       rd_addr,
  input  logic [3:0] code_q,
  input  logic       guard_out,
  input  logic       dly_flag,
  output logic       rd_valid,
  output logic [3:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= 4'd0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_addr ? {2'b00, guard_out, dly_flag} : code_q;
    end
  end

  p_valid_one_cycle_r8: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en));
endmodule

// File: rtl/dtmf_steer.sv
module dtmf_steer #(
  parameter int CNT_W      = 16,
  parameter int SETTLE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tone_ok,
  input  logic [1:0]       low_sel,
  input  logic [1:0]       high_sel,
  input  logic [CNT_W-1:0] on_guard,
  input  logic [CNT_W-1:0] off_guard,
  input  logic             int_en,
  input  logic             rd_en,
  input  logic             rd_addr,
  output logic             rd_valid,
  output logic [3:0]       rd_data,
  output logic             guard_out,
  output logic             dly_flag,
  output logic             int_n
);
  logic       accept;
  logic [3:0] code_q;

  dtmf_guard_fsm #(.CNT_W(CNT_W), .SETTLE_CYC(SETTLE_CYC)) u_fsm (
    .clk(clk), .rst(rst), .tone_ok(tone_ok), .on_guard(on_guard),
    .off_guard(off_guard), .accept(accept), .guard_out(guard_out),
    .dly_flag(dly_flag)
  );

  dtmf_code_latch u_latch (
    .clk(clk), .rst(rst), .load(accept), .low_sel(low_sel),
    .high_sel(high_sel), .code_q(code_q)
  );

  dtmf_reg_read u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .code_q(code_q),
    .guard_out(guard_out), .dly_flag(dly_flag), .rd_valid(rd_valid),
    .rd_data(rd_data)
  );

  assign int_n = !(dly_flag && int_en);

  p_code_only_with_tone_r5: assert property (@(posedge clk) disable iff (rst)
    !tone_ok |=> $stable(code_q));
  p_irq_idle_high_r9: assert property (@(posedge clk) disable iff (rst)
    !dly_flag |-> int_n);
endmodule

// File: tb/test_dtmf_steer.sv
module test_dtmf_steer;
  localparam int CW = 16;
  localparam int SD = 2;
  localparam int PG = 5;
  localparam int AG = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tone_ok = 1'b0;
  logic [1:0] low_sel = 2'd0, high_sel = 2'd0;
  logic [CW-1:0] on_guard = CW'(PG), off_guard = CW'(AG);
  logic int_en = 1'b0, rd_en = 1'b0, rd_addr = 1'b0;
  logic rd_valid, guard_out, dly_flag, int_n;
  logic [3:0] rd_data;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  dtmf_steer #(.CNT_W(CW), .SETTLE_CYC(SD)) i_dtmf_steer (
    .clk(clk), .rst(rst), .tone_ok(tone_ok), .low_sel(low_sel),
    .high_sel(high_sel), .on_guard(on_guard), .off_guard(off_guard),
    .int_en(int_en), .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_data(rd_data), .guard_out(guard_out), .dly_flag(dly_flag),
    .int_n(int_n)
  );

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] model(input logic [1:0] r, input logic [1:0] c);
    case ({r, c})
      4'b0000: return 4'd1;  4'b0001: return 4'd2;  4'b0010: return 4'd3;
      4'b0100: return 4'd4;  4'b0101: return 4'd5;  4'b0110: return 4'd6;
      4'b1000: return 4'd7;  4'b1001: return 4'd8;  4'b1010: return 4'd9;
      4'b1100: return 4'd11; 4'b1101: return 4'd10; 4'b1110: return 4'd12;
      4'b0011: return 4'd13; 4'b0111: return 4'd14; 4'b1011: return 4'd15;
      default: return 4'd0;
    endcase
  endfunction

  task automatic read_reg(input logic a, output logic [3:0] d);
    rd_en = 1'b1; rd_addr = a;
    tick(1);
    rd_en = 1'b0;
    chk("R8 valid", {3'b0, rd_valid}, 4'd1);
    d = rd_data;
    tick(1);
    chk("R8 valid drop", {3'b0, rd_valid}, 4'd0);
  endtask

  task automatic t_reset;
    logic [3:0] d;
    chk("R1 guard", {3'b0, guard_out}, 4'd0);
    chk("R1 flag", {3'b0, dly_flag}, 4'd0);
    chk("R1 int_n", {3'b0, int_n}, 4'd1);
    read_reg(1'b0, d);
    chk("R1 code", d, 4'd0);
  endtask

  task automatic t_short_burst;
    logic [3:0] d;
    low_sel = 2'd2; high_sel = 2'd2;
    tone_ok = 1'b1; tick(PG - 1);
    chk("R2 short guard", {3'b0, guard_out}, 4'd0);
    tone_ok = 1'b0; tick(SD + 2);
    chk("R2 short flag", {3'b0, dly_flag}, 4'd0);
    read_reg(1'b0, d);
    chk("R2 short code", d, 4'd0);
    tone_ok = 1'b1; tick(PG - 2);
    tone_ok = 1'b0; tick(1);
    tone_ok = 1'b1; tick(PG - 1);
    chk("R2 restart guard", {3'b0, guard_out}, 4'd0);
    tone_ok = 1'b0; tick(2);
  endtask

  task automatic t_accept_and_dropout;
    logic [3:0] d;
    low_sel = 2'd1; high_sel = 2'd1;
    tone_ok = 1'b1; tick(PG - 1);
    chk("R2 pre-accept", {3'b0, guard_out}, 4'd0);
    tick(1);
    chk("R3 guard on accept", {3'b0, guard_out}, 4'd1);
    chk("R4 no flag on accept", {3'b0, dly_flag}, 4'd0);
    tick(SD - 1);
    chk("R4 flag not yet", {3'b0, dly_flag}, 4'd0);
    tick(1);
    chk("R4 flag up", {3'b0, dly_flag}, 4'd1);
    read_reg(1'b0, d);
    chk("R7 digit 5", d, 4'd5);
    read_reg(1'b1, d);
    chk("R8 status", d, 4'b0011);
    low_sel = 2'd3; high_sel = 2'd3;
    tone_ok = 1'b0; tick(AG - 1);
    chk("R6 dropout bridged", {3'b0, dly_flag}, 4'd1);
    chk("R3 guard follows", {3'b0, guard_out}, 4'd0);
    tone_ok = 1'b1; tick(1);
    chk("R3 guard back", {3'b0, guard_out}, 4'd1);
    read_reg(1'b0, d);
    chk("R5 code held", d, 4'd5);
    tone_ok = 1'b0; tick(AG - 1);
    chk("R6 before release", {3'b0, dly_flag}, 4'd1);
    tick(1);
    chk("R6 released", {3'b0, dly_flag}, 4'd0);
    read_reg(1'b0, d);
    chk("R5 code after release", d, 4'd5);
  endtask

  task automatic t_irq;
    low_sel = 2'd0; high_sel = 2'd0; int_en = 1'b1;
    tone_ok = 1'b1; tick(PG + SD);
    chk("R9 int low", {3'b0, int_n}, 4'd0);
    int_en = 1'b0; tick(1);
    chk("R9 int masked", {3'b0, int_n}, 4'd1);
    tone_ok = 1'b0; tick(AG + 1);
  endtask

  task automatic t_sweep;
    logic [3:0] d;
    for (int k = 0; k < 16; k++) begin
      low_sel = 2'(k / 4); high_sel = 2'(k % 4);
      tone_ok = 1'b1; tick(PG + SD);
      read_reg(1'b0, d);
      chk("R7 sweep", d, model(2'(k / 4), 2'(k % 4)));
      tone_ok = 1'b0; tick(AG + 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick(3);
    rst = 1'b0;
    t_reset();
    t_short_burst();
    t_accept_and_dropout();
    t_irq();
    t_sweep();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule